// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Classifier

This block turns two comparator-limited square waves, one carrying the low-group tone and one the high-group tone, into a decoded telephone keypad digit. It runs from a single system clock (3.579545 MHz by default) and measures each input's period as the number of clock cycles between consecutive rising edges. Each measured period is matched against four acceptance windows per group. A group is accepted only after several consecutive periods fall in the same window, which tolerates small frequency error while rejecting short bursts of speech or noise.

When both groups hold an accepted tone, the block raises a presence flag and registers a 4-bit key code built from the column and row indices. An inhibit input removes the fourth column (the 1633 Hz tone) from recognition. A group that stops toggling is dropped after a timeout slightly longer than the slowest valid period. The analog band-splitting, dial-tone rejection and limiting comparators sit upstream and are not part of this block.

Top module: `dtmf_receiver`

## Requirements
- R1: Each input is passed through a two-stage synchronizer. Its period is measured as the number of clock cycles from one synchronized rising edge to the next. The first rising edge after reset or after a timeout only starts a measurement.
- R2: Low-group rows 0 to 3 correspond to 697, 770, 852 and 941 Hz. High-group columns 0 to 3 correspond to 1209, 1336, 1477 and 1633 Hz. A period falls in a bin when it lies within ±TOL_PPT/1000 (default 15) of round(CLK_HZ/f) cycles.
- R3: A group becomes valid only after RUN_LEN (default 4) consecutive measured periods fall in the same bin. A change of bin restarts the count at one and drops the group's valid state.
- R4: tonePresent is high only while both groups are valid. It falls on the clock edge after either group loses validity.
- R5: A measured period that falls in no bin clears that group's valid state and its run count.
- R6: While inhibitCol4 is high, a high group in column 3 never asserts tonePresent.
- R7: keyCode is {column[1:0], row[1:0]}. It is loaded on the same edge at which tonePresent is (or stays) high, and it holds its value whenever tonePresent is low.
- R8: If no rising edge arrives on a group's input within round(CLK_HZ/697)·9/8 cycles of the previous edge, that group becomes invalid. It does not become invalid earlier while edges keep arriving within valid periods.
- R9: After reset, keyCode is 0 and tonePresent is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 3.579545 MHz |
| rstN | input | 1 | Active-low synchronous reset |
| lowTone | input | 1 | Limited low-group tone, asynchronous |
| highTone | input | 1 | Limited high-group tone, asynchronous |
| inhibitCol4 | input | 1 | High: column 3 keys are not recognised |
| keyCode | output | 4 | Registered key code {column, row} |
| tonePresent | output | 1 | Both groups hold a valid tone |

## Verification
The bound checker watches four rules on every cycle. The presence flag must drop on the edge after either group loses validity. A group's valid flag may rise only right after a matching period measurement. A miss or a timeout must clear the group. The key code may change only while the flag is high, and an inhibited column-3 code may never appear with the flag set. Only the bench's scenarios can show that the windows sit at the right frequencies, that every one of the 16 pairs maps to its code, that tolerance and rejection behave at the window edges, and that the qualification and timeout delays are as long as required.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  // Per-group measurement report from datapath to control
  typedef struct packed {
    logic       strobe;   // a period was measured this cycle
    logic       hit;      // the period lies in one of the four bins
    logic       same;     // hit in the same bin as the previous hit
    logic       timeout;  // no edge within the timeout window
    logic [1:0] binIdx;   // bin of the most recent hit
  } groupMeas_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCode;
  } ctrlStrobe_t;

  function automatic int unsigned toneHz(input logic hiGroup, input logic [1:0] idx);
    int unsigned hz;
    if (!hiGroup) begin
      case (idx)
        2'd0: hz = 697;
        2'd1: hz = 770;
        2'd2: hz = 852;
        default: hz = 941;
      endcase
    end else begin
      case (idx)
        2'd0: hz = 1209;
        2'd1: hz = 1336;
        2'd2: hz = 1477;
        default: hz = 1633;
      endcase
    end
    return hz;
  endfunction

  function automatic int unsigned nomPeriod(input int unsigned clkHz, input int unsigned hz);
    return (clkHz + hz / 2) / hz;
  endfunction

endpackage

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
  parameter int unsigned CNT_W       = 13,
  parameter int unsigned TIMEOUT_CYC = 5778
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             toneIn,
  output logic             periodStrobe,
  output logic [CNT_W-1:0] periodVal,
  output logic             timeoutStrobe
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  logic syncA, syncB, syncPrev;
  logic rise;
  logic armed;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= toneIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign rise = syncB & ~syncPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt           <= '0;
      armed         <= 1'b0;
      periodStrobe  <= 1'b0;
      periodVal     <= '0;
      timeoutStrobe <= 1'b0;
    end else begin
      periodStrobe  <= 1'b0;
      timeoutStrobe <= 1'b0;
      if (rise) begin
        periodStrobe <= armed;
        periodVal    <= cnt;
        armed        <= 1'b1;
        cnt          <= CNT_W'(1);
      end else if (cnt >= LIMIT) begin
        if (armed) begin
          timeoutStrobe <= 1'b1;
        end
        armed <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/dtmf_bin_classifier.sv
module dtmf_bin_classifier
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 3579545,
  parameter int unsigned TOL_PPT  = 15,
  parameter bit          HI_GROUP = 1'b0,
  parameter int unsigned CNT_W    = 13
) (
  input  logic [CNT_W-1:0] period,
  output logic             hit,
  output logic [1:0]       binIdx
);

  logic [3:0] hitVec;

  for (genvar g = 0; g < 4; g++) begin : gBin
    localparam int unsigned NOM = nomPeriod(CLK_HZ, toneHz(HI_GROUP, 2'(g)));
    localparam int unsigned DEV = (NOM * TOL_PPT) / 1000;
    localparam logic [CNT_W-1:0] LO_C = CNT_W'(NOM - DEV);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(NOM + DEV);
    assign hitVec[g] = (period >= LO_C) && (period <= HI_C);
  end

  always_comb begin
    binIdx = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (hitVec[i]) begin
        binIdx = 2'(i);
      end
    end
  end

  assign hit = |hitVec;

endmodule

// File: rtl/dtmf_datapath.sv
module dtmf_datapath
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 3579545,
  parameter int unsigned TOL_PPT     = 15,
  parameter int unsigned CNT_W       = 13,
  parameter int unsigned TIMEOUT_CYC = 5778
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lowTone,
  input  logic        highTone,
  input  ctrlStrobe_t strobes,
  output groupMeas_t  lowMeas,
  output groupMeas_t  highMeas,
  output logic [3:0]  keyCode
);

  groupMeas_t meas [2];
  logic [1:0] toneVec;

  assign toneVec = {highTone, lowTone};

  for (genvar gi = 0; gi < 2; gi++) begin : gGroup
    logic             pStrobe;
    logic [CNT_W-1:0] pVal;
    logic             tStrobe;
    logic             binHit;
    logic [1:0]       binNow;
    logic [1:0]       lastIdx;
    logic             haveLast;

    dtmf_period_meter #(
      .CNT_W      (CNT_W),
      .TIMEOUT_CYC(TIMEOUT_CYC)
    ) uMeter (
      .clk          (clk),
      .rstN         (rstN),
      .toneIn       (toneVec[gi]),
      .periodStrobe (pStrobe),
      .periodVal    (pVal),
      .timeoutStrobe(tStrobe)
    );

    dtmf_bin_classifier #(
      .CLK_HZ  (CLK_HZ),
      .TOL_PPT (TOL_PPT),
      .HI_GROUP(gi == 1),
      .CNT_W   (CNT_W)
    ) uClass (
      .period(pVal),
      .hit   (binHit),
      .binIdx(binNow)
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lastIdx  <= 2'd0;
        haveLast <= 1'b0;
      end else if (tStrobe) begin
        haveLast <= 1'b0;
      end else if (pStrobe) begin
        haveLast <= binHit;
        if (binHit) begin
          lastIdx <= binNow;
        end
      end
    end

    always_comb begin
      meas[gi].strobe  = pStrobe;
      meas[gi].hit     = binHit;
      meas[gi].same    = binHit && haveLast && (binNow == lastIdx);
      meas[gi].timeout = tStrobe;
      meas[gi].binIdx  = lastIdx;
    end
  end

  assign lowMeas  = meas[0];
  assign highMeas = meas[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyCode <= 4'd0;
    end else if (strobes.loadCode) begin
      keyCode <= {highMeas.binIdx, lowMeas.binIdx};
    end
  end

endmodule

// File: rtl/dtmf_ctrl.sv
module dtmf_ctrl
  import dtmf_pkg::*;
#(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  groupMeas_t  lowMeas,
  input  groupMeas_t  highMeas,
  input  logic        inhibitCol4,
  output ctrlStrobe_t strobes,
  output logic [1:0]  validQ,
  output logic        tonePresent
);

  localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

  groupMeas_t meas [2];
  logic presentNext;

  assign meas[0] = lowMeas;
  assign meas[1] = highMeas;

  for (genvar gi = 0; gi < 2; gi++) begin : gQual
    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] runInc;

    assign runInc = (run < RUN_MAX) ? run + RUN_W'(1) : RUN_MAX;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        run        <= '0;
        validQ[gi] <= 1'b0;
      end else if (meas[gi].timeout) begin
        run        <= '0;
        validQ[gi] <= 1'b0;
      end else if (meas[gi].strobe) begin
        if (!meas[gi].hit) begin
          run        <= '0;
          validQ[gi] <= 1'b0;
        end else if (meas[gi].same) begin
          run        <= runInc;
          validQ[gi] <= (runInc >= RUN_MAX);
        end else begin
          run        <= RUN_W'(1);
          validQ[gi] <= (RUN_MAX <= RUN_W'(1));
        end
      end
    end
  end

  assign presentNext = validQ[0] && validQ[1] &&
                       !(inhibitCol4 && (highMeas.binIdx == 2'd3));

  assign strobes.loadCode = presentNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tonePresent <= 1'b0;
    end else begin
      tonePresent <= presentNext;
    end
  end

endmodule

// File: rtl/dtmf_receiver.sv
module dtmf_receiver
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned TOL_PPT = 15,
  parameter int unsigned RUN_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowTone,
  input  logic       highTone,
  input  logic       inhibitCol4,
  output logic [3:0] keyCode,
  output logic       tonePresent
);

  localparam int unsigned MAX_PERIOD  = nomPeriod(CLK_HZ, 697);
  localparam int unsigned TIMEOUT_CYC = MAX_PERIOD + MAX_PERIOD / 8;
  localparam int unsigned CNT_W       = $clog2(TIMEOUT_CYC + 2);

  groupMeas_t  lowMeas;
  groupMeas_t  highMeas;
  ctrlStrobe_t strobes;
  logic [1:0]  validQ;

  dtmf_datapath #(
    .CLK_HZ     (CLK_HZ),
    .TOL_PPT    (TOL_PPT),
    .CNT_W      (CNT_W),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .lowTone (lowTone),
    .highTone(highTone),
    .strobes (strobes),
    .lowMeas (lowMeas),
    .highMeas(highMeas),
    .keyCode (keyCode)
  );

  dtmf_ctrl #(
    .RUN_LEN(RUN_LEN)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .lowMeas    (lowMeas),
    .highMeas   (highMeas),
    .inhibitCol4(inhibitCol4),
    .strobes    (strobes),
    .validQ     (validQ),
    .tonePresent(tonePresent)
  );

endmodule

// File: rtl/dtmf_receiver_chk.sv
module dtmf_receiver_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inhibitCol4,
  input logic [3:0] keyCode,
  input logic       tonePresent,
  input logic       lowValid,
  input logic       highValid,
  input logic       lowStrobe,
  input logic       lowHit,
  input logic       lowSame,
  input logic       lowTimeout,
  input logic       highStrobe,
  input logic       highHit,
  input logic       highTimeout
);

  AST_PRESENT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (!lowValid || !highValid) |=> !tonePresent); // R4

  AST_LOW_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowValid) |-> $past(lowStrobe && lowHit && lowSame)); // R3

  AST_LOW_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (lowStrobe && !lowHit) |=> !lowValid); // R5

  AST_HIGH_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (highStrobe && !highHit) |=> !highValid); // R5

  AST_LOW_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    lowTimeout |=> !lowValid); // R8

  AST_HIGH_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    highTimeout |=> !highValid); // R8

  AST_NO_COL4_INHIBITED: assert property (@(posedge clk) disable iff (!rstN)
    (tonePresent && $past(inhibitCol4)) |-> (keyCode[3:2] != 2'd3)); // R6

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(keyCode) |-> tonePresent); // R7

endmodule

bind dtmf_receiver dtmf_receiver_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inhibitCol4(inhibitCol4),
  .keyCode    (keyCode),
  .tonePresent(tonePresent),
  .lowValid   (validQ[0]),
  .highValid  (validQ[1]),
  .lowStrobe  (lowMeas.strobe),
  .lowHit     (lowMeas.hit),
  .lowSame    (lowMeas.same),
  .lowTimeout (lowMeas.timeout),
  .highStrobe (highMeas.strobe),
  .highHit    (highMeas.hit),
  .highTimeout(highMeas.timeout)
);

// File: tb/dtmf_receiver_test.sv
module dtmf_receiver_test;

  localparam int unsigned SIM_HZ = 358000;
  localparam int unsigned TMO    = ((SIM_HZ + 348) / 697) * 9 / 8;

  // {row[1:0], col[1:0], expected code[3:0]}
  localparam logic [7:0] VECS [16] = '{
    8'b00_00_0000, 8'b01_00_0001, 8'b10_00_0010, 8'b11_00_0011,
    8'b00_01_0100, 8'b01_01_0101, 8'b10_01_0110, 8'b11_01_0111,
    8'b11_10_1011, 8'b10_10_1010, 8'b01_10_1001, 8'b00_10_1000,
    8'b11_11_1111, 8'b10_11_1110, 8'b01_11_1101, 8'b00_11_1100
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowTone, highTone, inhibitCol4;
  logic [3:0] keyCode;
  logic tonePresent;

  int total = 0;
  int bad = 0;
  int lowPer = 0, highPer = 0, lowPh = 0, highPh = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dtmf_receiver #(.CLK_HZ(SIM_HZ)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .lowTone    (lowTone),
    .highTone   (highTone),
    .inhibitCol4(inhibitCol4),
    .keyCode    (keyCode),
    .tonePresent(tonePresent)
  );

  // square-wave generators, updated away from the sampling edge
  always @(negedge clk) begin
    if (lowPer == 0) begin
      lowPh <= 0; lowTone <= 1'b0;
    end else begin
      lowTone <= (lowPh < lowPer / 2);
      lowPh   <= (lowPh + 1 >= lowPer) ? 0 : lowPh + 1;
    end
    if (highPer == 0) begin
      highPh <= 0; highTone <= 1'b0;
    end else begin
      highTone <= (highPh < highPer / 2);
      highPh   <= (highPh + 1 >= highPer) ? 0 : highPh + 1;
    end
  end

  function automatic int perOf(input bit hi, input logic [1:0] idx);
    int hz;
    int lowF [4]  = '{697, 770, 852, 941};
    int highF [4] = '{1209, 1336, 1477, 1633};
    hz = hi ? highF[idx] : lowF[idx];
    return (SIM_HZ * 10 / hz + 5) / 10;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setTones(input int lp, input int hp);
    @(posedge clk);
    lowPer  = lp;
    highPer = hp;
  endtask

  task automatic silence();
    setTones(0, 0);
    waitCyc(2 * TMO + 50);
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    inhibitCol4 = 1'b0;
    waitCyc(5);
    chk("R9 present after reset", tonePresent, 0);
    chk("R9 code after reset", keyCode, 0);
    rstN = 1'b1;
    waitCyc(5);

    // R1 R2 R3 R4 R7: every key pair, qualification timing, then code
    for (int v = 0; v < 16; v++) begin
      logic [1:0] row, col;
      int lp;
      row = VECS[v][7:6];
      col = VECS[v][5:4];
      lp  = perOf(1'b0, row);
      silence();
      chk("R4 present low after silence", tonePresent, 0);
      setTones(lp, perOf(1'b1, col));
      waitCyc(lp * 7 / 2);
      chk("R3 not yet qualified at 3.5 periods", tonePresent, 0);
      waitCyc(lp * 5 / 2);
      chk("R2 pair recognised", tonePresent, 1);
      chk("R7 R1 key code", keyCode, VECS[v][3:0]);
    end

    // R6: inhibit blocks column 3, code keeps previous value
    silence();
    setTones(perOf(1'b0, 2'd1), perOf(1'b1, 2'd0));
    waitCyc(perOf(1'b0, 2'd1) * 6);
    chk("R7 setup code", keyCode, 4'h1);
    silence();
    inhibitCol4 = 1'b1;
    setTones(perOf(1'b0, 2'd2), perOf(1'b1, 2'd3));
    waitCyc(perOf(1'b0, 2'd2) * 6);
    chk("R6 inhibited column not present", tonePresent, 0);
    chk("R7 code held while inhibited", keyCode, 4'h1);
    inhibitCol4 = 1'b0;
    waitCyc(10);
    chk("R6 present after inhibit released", tonePresent, 1);
    chk("R6 code after inhibit released", keyCode, 4'hE);

    // R6: inhibit leaves other columns alone
    silence();
    inhibitCol4 = 1'b1;
    setTones(perOf(1'b0, 2'd3), perOf(1'b1, 2'd2));
    waitCyc(perOf(1'b0, 2'd3) * 6);
    chk("R6 column 2 unaffected", tonePresent, 1);
    chk("R6 column 2 code", keyCode, 4'hB);
    inhibitCol4 = 1'b0;

    // R2: +1% deviation accepted
    silence();
    setTones(perOf(1'b0, 2'd0) * 101 / 100, perOf(1'b1, 2'd0));
    waitCyc(perOf(1'b0, 2'd0) * 6);
    chk("R2 1pct deviation accepted", tonePresent, 1);
    chk("R2 code with deviation", keyCode, 4'h0);

    // R5: low tone drifts out of window, presence falls, code holds
    setTones(perOf(1'b0, 2'd0) * 104 / 100, perOf(1'b1, 2'd0));
    waitCyc(perOf(1'b0, 2'd0) * 3);
    chk("R5 out-of-window rejected", tonePresent, 0);
    chk("R7 code held after reject", keyCode, 4'h0);

    // R4: low group alone never gives presence
    silence();
    setTones(perOf(1'b0, 2'd2), 0);
    waitCyc(perOf(1'b0, 2'd2) * 7);
    chk("R4 single group not present", tonePresent, 0);

    // R8: timeout after high tone stops
    silence();
    setTones(perOf(1'b0, 2'd1), perOf(1'b1, 2'd1));
    waitCyc(perOf(1'b0, 2'd1) * 6);
    chk("R8 setup present", tonePresent, 1);
    setTones(perOf(1'b0, 2'd1), 0);
    waitCyc(100);
    chk("R8 still present before timeout", tonePresent, 1);
    waitCyc(TMO + 100);
    chk("R8 timeout drops presence", tonePresent, 0);
    chk("R7 code held after timeout", keyCode, 4'h5);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule